// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Block

This block is a configurable sum-of-products logic block of the kind found in a complex programmable logic device. Each block input is turned into a true line and a complement line. A fuse-programmable AND plane combines any selection of these lines into product terms. The terms are grouped into fixed clusters of five, one cluster per macrocell, and three further terms serve the whole block as a shared clock, a shared clear and a shared output enable.

Each macrocell ORs the cluster terms it does not claim for control into a fast sum. It then presents that sum either directly or through a register. The register takes its clock from the global clock, the shared clock term or its own cluster clock term. It has asynchronous preset and clear, and the clear wins when both are asserted. The output enable comes from a constant, the shared enable term or the cluster enable term. The pad is driven only while that enable is high.

All fuses and mode bits sit in one serial shift chain. The chain is loaded most-significant bit first while a load pin is held high. While loading, every product term is forced to 0.

Top module: `sop_logic_block`

## Requirements
- R1: Block input i appears on array line 2i in true form and on line 2i+1 in complement form. A product term is the AND of every line whose fuse is set for it.
- R2: A product term with no fuse set evaluates to 0.
- R3: Cluster k consists of product terms 5k to 5k+4. Terms 5*N_MC, 5*N_MC+1 and 5*N_MC+2 are the shared clock, the shared clear and the shared output enable.
- R4: The macrocell sum is the OR of those of its five cluster terms whose withdraw flag (mode bits 0 to 4) is clear. With mode bit 5 at 0, mc_dout equals this sum.
- R5: With mode bit 5 at 1, mc_dout is a register that captures the sum on the rising edge of the selected clock. The clock select (mode bits 7:6) is 0 or 3 for the global clk, 1 for the shared clock term, and 2 for cluster term 2, which is used only if its flag is set and is otherwise a constant 0.
- R6: Cluster term 3, when flagged, presets the register asynchronously. Cluster term 4, when flagged, clears it asynchronously, and so does the shared clear term when mode bit 10 is 1. The clear takes priority over the preset.
- R7: The output-enable select (mode bits 9:8) is 0 for always on, 1 for the shared enable term, 2 for cluster term 0 (only if flagged, otherwise 0) and 3 for off. mc_oe reports the result, and mc_pad is high impedance whenever mc_oe is 0.
- R8: While cfg_load is 1, the chain shifts left by one bit on each rising cfg_clk edge and takes cfg_din into bit 0, so the first bit sent ends at the top. Macrocell m's mode bits are chain bits m*11 to m*11+10. The fuse for term p and line l is chain bit 11*N_MC + p*2*N_IN + l. While cfg_load is 0, the chain holds.
- R9: While cfg_load is 1, every product term is forced to 0.
- R10: A synchronous rst on cfg_clk clears the whole chain. Every cell is then combinational with output enable always on and mc_dout at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global macrocell clock |
| rst | input | 1 | Synchronous clear of the configuration chain |
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_load | input | 1 | Shift enable; blanks all product terms while high |
| cfg_din | input | 1 | Serial configuration data |
| in_i | input | N_IN | Block inputs to the AND plane |
| mc_dout | output | N_MC | Macrocell output values |
| mc_oe | output | N_MC | Selected output enable per macrocell |
| mc_pad | output | N_MC | Macrocell outputs, high impedance when not enabled |

## Verification
The hardest condition to expose at the ports is the blanking during a load. Once shifting starts, the configuration is already scrambled, so a product term forced to 0 looks no different from one that happens to evaluate to 0. The bench therefore loads a pattern whose fuse bit, after eight further zero shifts, lands on another term of the same cluster that would read as 1. It then stops partway through a load and expects a 0. The asynchronous preset and clear are driven by input-controlled terms while the cell's clock term is left unflagged. This shows that the register changes with no clock edge and that the clear wins.

// File: rtl/sop_pkg.sv
package sop_pkg;

    localparam int CLUSTER   = 5;
    localparam int N_SHARED  = 3;
    localparam int MC_CFG_W  = 11;

    localparam int CT_OE  = 0;
    localparam int CT_CLK = 2;
    localparam int CT_SET = 3;
    localparam int CT_CLR = 4;

    typedef enum logic [1:0] {
        CLK_GLOBAL     = 2'd0,
        CLK_SHARED     = 2'd1,
        CLK_CLUSTER    = 2'd2,
        CLK_GLOBAL_ALT = 2'd3
    } clk_sel_e;

    typedef enum logic [1:0] {
        OE_ON      = 2'd0,
        OE_SHARED  = 2'd1,
        OE_CLUSTER = 2'd2,
        OE_OFF     = 2'd3
    } oe_sel_e;

    typedef struct packed {
        logic       srst_en;
        oe_sel_e    oe_sel;
        clk_sel_e   clk_sel;
        logic       reg_en;
        logic [4:0] ctl;
    } mc_cfg_t;

    typedef struct packed {
        logic clk;
        logic clr;
        logic oe;
    } shared_ctl_t;

    function automatic int num_terms(int n_mc);
        return n_mc * CLUSTER + N_SHARED;
    endfunction

    function automatic int cfg_bits(int n_in, int n_mc);
        return num_terms(n_mc) * 2 * n_in + n_mc * MC_CFG_W;
    endfunction

endpackage

// File: rtl/sop_cfg_chain.sv
module sop_cfg_chain #(
    parameter int W = 16
) (
    input  logic         cfg_clk,
    input  logic         rst,
    input  logic         load,
    input  logic         din,
    output logic [W-1:0] bits
);

    always_ff @(posedge cfg_clk) begin
        if (rst)
            bits <= '0;
        else if (load)
            bits <= {bits[W-2:0], din};
    end

    assert_chain_holds_R8: assert property (@(posedge cfg_clk) disable iff (rst)
        !load |=> $stable(bits));

endmodule

// File: rtl/sop_and_array.sv
module sop_and_array #(
    parameter int N_IN = 4,
    parameter int N_PT = 13
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_IN-1:0]          in_i,
    input  logic [N_PT*2*N_IN-1:0]   fuse,
    input  logic                     blank,
    output logic [N_PT-1:0]          pt
);

    localparam int L = 2 * N_IN;

    logic [L-1:0] lines;

    generate
        for (genvar i = 0; i < N_IN; i++) begin : g_lines
            assign lines[2*i]   = in_i[i];
            assign lines[2*i+1] = ~in_i[i];
        end
        for (genvar p = 0; p < N_PT; p++) begin : g_terms
            logic [L-1:0] row;
            assign row   = fuse[p*L +: L];
            // empty rows read as 0; unconnected lines are masked to 1
            assign pt[p] = !blank && (|row) && (&(lines | ~row));
        end
    endgenerate

    assert_blank_terms_R9: assert property (@(posedge clk) disable iff (rst)
        blank |-> (pt == '0));

endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
    import sop_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  terms,
    input  shared_ctl_t shr,
    input  mc_cfg_t     cfg,
    output logic        dout,
    output logic        oe
);

    logic sum;
    logic mc_clk;
    logic set_a;
    logic clr_a;
    logic q;

    assign sum   = |(terms & ~cfg.ctl);
    assign set_a = cfg.ctl[CT_SET] & terms[CT_SET];
    assign clr_a = (cfg.ctl[CT_CLR] & terms[CT_CLR]) | (cfg.srst_en & shr.clr);

    always_comb begin
        case (cfg.clk_sel)
            CLK_SHARED:  mc_clk = shr.clk;
            CLK_CLUSTER: mc_clk = cfg.ctl[CT_CLK] & terms[CT_CLK];
            default:     mc_clk = clk;
        endcase
    end

    always_comb begin
        case (cfg.oe_sel)
            OE_ON:      oe = 1'b1;
            OE_SHARED:  oe = shr.oe;
            OE_CLUSTER: oe = cfg.ctl[CT_OE] & terms[CT_OE];
            default:    oe = 1'b0;
        endcase
    end

    always_ff @(posedge mc_clk or posedge clr_a or posedge set_a) begin
        if (clr_a)
            q <= 1'b0;
        else if (set_a)
            q <= 1'b1;
        else
            q <= sum;
    end

    assign dout = cfg.reg_en ? q : sum;

    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_a && cfg.reg_en) |-> !dout);

    assert_preset_sets_R6: assert property (@(posedge clk) disable iff (rst)
        (set_a && !clr_a && cfg.reg_en) |-> dout);

    assert_withdrawn_sum_R4: assert property (@(posedge clk) disable iff (rst)
        ((&cfg.ctl) && !cfg.reg_en) |-> !dout);

    assert_off_disables_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg.oe_sel == OE_OFF) |-> !oe);

endmodule

// File: rtl/sop_logic_block.sv
module sop_logic_block
    import sop_pkg::*;
#(
    parameter int N_IN = 4,
    parameter int N_MC = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_clk,
    input  logic            cfg_load,
    input  logic            cfg_din,
    input  logic [N_IN-1:0] in_i,
    output logic [N_MC-1:0] mc_dout,
    output logic [N_MC-1:0] mc_oe,
    output logic [N_MC-1:0] mc_pad
);

    localparam int N_PT     = num_terms(N_MC);
    localparam int L        = 2 * N_IN;
    localparam int MC_TOTAL = N_MC * MC_CFG_W;
    localparam int CFG_W    = cfg_bits(N_IN, N_MC);
    localparam int SH_BASE  = N_MC * CLUSTER;

    logic [CFG_W-1:0] chain;
    logic [N_PT-1:0]  pt;
    shared_ctl_t      shr;

    sop_cfg_chain #(.W(CFG_W)) u_chain (
        .cfg_clk (cfg_clk),
        .rst     (rst),
        .load    (cfg_load),
        .din     (cfg_din),
        .bits    (chain)
    );

    sop_and_array #(.N_IN(N_IN), .N_PT(N_PT)) u_array (
        .clk   (clk),
        .rst   (rst),
        .in_i  (in_i),
        .fuse  (chain[CFG_W-1:MC_TOTAL]),
        .blank (cfg_load),
        .pt    (pt)
    );

    assign shr.clk = pt[SH_BASE];
    assign shr.clr = pt[SH_BASE+1];
    assign shr.oe  = pt[SH_BASE+2];

    generate
        for (genvar m = 0; m < N_MC; m++) begin : g_mc
            mc_cfg_t mcfg;
            assign mcfg = mc_cfg_t'(chain[m*MC_CFG_W +: MC_CFG_W]);

            sop_macrocell u_mc (
                .clk   (clk),
                .rst   (rst),
                .terms (pt[m*CLUSTER +: CLUSTER]),
                .shr   (shr),
                .cfg   (mcfg),
                .dout  (mc_dout[m]),
                .oe    (mc_oe[m])
            );

            assign mc_pad[m] = mc_oe[m] ? mc_dout[m] : 1'bz;
        end
    endgenerate

endmodule

// File: tb/tb_sop_logic_block.sv
module tb_sop_logic_block;
    import sop_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N_IN     = 4;
    localparam int N_MC     = 2;
    localparam int L        = 2 * N_IN;
    localparam int MC_TOTAL = N_MC * MC_CFG_W;
    localparam int W        = cfg_bits(N_IN, N_MC);
    localparam int SH_BASE  = N_MC * CLUSTER;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_load = 1'b0;
    logic            cfg_din = 1'b0;
    logic [N_IN-1:0] in_v = '0;
    logic [N_MC-1:0] mc_dout;
    logic [N_MC-1:0] mc_oe;
    wire  [N_MC-1:0] mc_pad;

    logic [W-1:0] cfg;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sop_logic_block #(.N_IN(N_IN), .N_MC(N_MC)) dut (
        .clk      (clk),
        .rst      (rst),
        .cfg_clk  (clk),
        .cfg_load (cfg_load),
        .cfg_din  (cfg_din),
        .in_i     (in_v),
        .mc_dout  (mc_dout),
        .mc_oe    (mc_oe),
        .mc_pad   (mc_pad)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b time=%0t", req, act, exp, $time);
        end
    endtask

    task automatic fuse(input int p, input int line);
        cfg[MC_TOTAL + p*L + line] = 1'b1;
    endtask

    task automatic put_mc(input int m, input mc_cfg_t c);
        cfg[m*MC_CFG_W +: MC_CFG_W] = c;
    endtask

    function automatic mc_cfg_t get_mc(input int m);
        return mc_cfg_t'(cfg[m*MC_CFG_W +: MC_CFG_W]);
    endfunction

    function automatic logic exp_pt(input int p, input logic [N_IN-1:0] x);
        logic [L-1:0] lines;
        logic [L-1:0] row;
        for (int i = 0; i < N_IN; i++) begin
            lines[2*i]   = x[i];
            lines[2*i+1] = ~x[i];
        end
        row = cfg[MC_TOTAL + p*L +: L];
        return (|row) && (&(lines | ~row));
    endfunction

    function automatic logic exp_sum(input int m, input logic [N_IN-1:0] x);
        mc_cfg_t c = get_mc(m);
        logic s = 1'b0;
        for (int j = 0; j < CLUSTER; j++)
            if (!c.ctl[j]) s = s | exp_pt(m*CLUSTER + j, x);
        return s;
    endfunction

    function automatic logic exp_oe(input int m, input logic [N_IN-1:0] x);
        mc_cfg_t c = get_mc(m);
        case (c.oe_sel)
            OE_ON:      return 1'b1;
            OE_SHARED:  return exp_pt(SH_BASE + 2, x);
            OE_CLUSTER: return c.ctl[0] & exp_pt(m*CLUSTER, x);
            default:    return 1'b0;
        endcase
    endfunction

    task automatic load_cfg();
        @(negedge clk);
        for (int i = W-1; i >= 0; i--) begin
            cfg_din  = cfg[i];
            cfg_load = 1'b1;
            @(negedge clk);
        end
        cfg_load = 1'b0;
        cfg_din  = 1'b0;
    endtask

    task automatic set_in(input logic [N_IN-1:0] v);
        @(negedge clk);
        in_v = v;
        #1;
    endtask

    task automatic sweep_comb(input string req);
        for (int v = 0; v < (1 << N_IN); v++) begin
            set_in(N_IN'(v));
            for (int m = 0; m < N_MC; m++) begin
                chk(req, mc_dout[m], exp_sum(m, N_IN'(v)));
                chk(req, mc_oe[m], exp_oe(m, N_IN'(v)));
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        mc_cfg_t c;
        void'($urandom(32'h5a17));

        // R10: reset clears chain -> combinational, always enabled, output 0
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        set_in(4'hF);
        for (int m = 0; m < N_MC; m++) begin
            chk("R10 dout after reset", mc_dout[m], 1'b0);
            chk("R10 oe after reset", mc_oe[m], 1'b1);
        end

        // R1: complement and true lines ANDed: mc0 term1 = ~in0 & in1
        cfg = '0;
        fuse(1, 1); fuse(1, 2);
        load_cfg();
        for (int v = 0; v < 16; v++) begin
            set_in(N_IN'(v));
            chk("R1 true/complement AND", mc_dout[0], ~v[0] & v[1]);
        end

        // R2: mc0 cluster empty, mc1 programmed; mc0 stays 0
        cfg = '0;
        fuse(5, 0); fuse(7, 3);
        load_cfg();
        for (int v = 0; v < 16; v++) begin
            set_in(N_IN'(v));
            chk("R2 empty terms give 0", mc_dout[0], 1'b0);
            chk("R3 cluster1 terms", mc_dout[1], v[0] | ~v[1]);
        end

        // R3/R7: shared OE term follows in1
        cfg = '0;
        c = '0; c.oe_sel = OE_SHARED;
        put_mc(0, c);
        fuse(SH_BASE + 2, 2);
        load_cfg();
        set_in(4'b0000);
        chk("R3 shared OE term low", mc_oe[0], 1'b0);
        set_in(4'b0010);
        chk("R3 shared OE term high", mc_oe[0], 1'b1);
        chk("R7 always-on OE of mc1", mc_oe[1], 1'b1);

        // R9: load blanks terms. mc0 term1 = in0; after 8 zero shifts the
        // fuse lands on term2 (flag clear) which would read 1 without blanking
        cfg = '0;
        fuse(1, 0);
        load_cfg();
        set_in(4'b0001);
        chk("R9 before load", mc_dout[0], 1'b1);
        cfg_din = 1'b0;
        cfg_load = 1'b1;
        repeat (8) @(negedge clk);
        #1;
        chk("R9 terms blank during load", mc_dout[0], 1'b0);
        chk("R9 oe during load", mc_oe[0], 1'b1);
        cfg_load = 1'b0;
        @(negedge clk);
        #1;
        chk("R8 shifted fuse after partial load", mc_dout[0], 1'b1);

        // R5: global clock registered
        cfg = '0;
        c = '0; c.reg_en = 1'b1; c.clk_sel = CLK_GLOBAL;
        put_mc(0, c);
        fuse(1, 0);
        load_cfg();
        set_in(4'b0000);
        @(negedge clk); #1;
        chk("R5 global reg 0", mc_dout[0], 1'b0);
        set_in(4'b0001);
        chk("R5 global reg holds before edge", mc_dout[0], 1'b0);
        @(negedge clk); #1;
        chk("R5 global reg captures", mc_dout[0], 1'b1);

        // R5: cluster clock term 2 = in3
        cfg = '0;
        c = '0; c.reg_en = 1'b1; c.clk_sel = CLK_CLUSTER; c.ctl[2] = 1'b1;
        put_mc(0, c);
        fuse(1, 0); fuse(2, 6);
        load_cfg();
        set_in(4'b0000);
        set_in(4'b1000);
        chk("R5 cluster clock captures 0", mc_dout[0], 1'b0);
        set_in(4'b1001);
        repeat (2) @(negedge clk); #1;
        chk("R5 global clock ignored", mc_dout[0], 1'b0);
        set_in(4'b0001);
        set_in(4'b1001);
        chk("R5 cluster clock captures 1", mc_dout[0], 1'b1);

        // R5/R3: shared clock term (first after clusters) = in2
        cfg = '0;
        c = '0; c.reg_en = 1'b1; c.clk_sel = CLK_SHARED;
        put_mc(0, c);
        fuse(1, 0); fuse(SH_BASE, 4);
        load_cfg();
        set_in(4'b0000);
        set_in(4'b0100);
        chk("R5 shared clock captures 0", mc_dout[0], 1'b0);
        set_in(4'b0101);
        repeat (2) @(negedge clk); #1;
        chk("R5 shared clock not toggled", mc_dout[0], 1'b0);
        set_in(4'b0001);
        set_in(4'b0101);
        chk("R5 shared clock captures 1", mc_dout[0], 1'b1);

        // R6: preset term3 = in1, clear term4 = in1&in2, shared clear = in3
        cfg = '0;
        c = '0; c.reg_en = 1'b1; c.clk_sel = CLK_CLUSTER;
        c.ctl[3] = 1'b1; c.ctl[4] = 1'b1; c.srst_en = 1'b1;
        put_mc(0, c);
        fuse(3, 2); fuse(4, 2); fuse(4, 4); fuse(SH_BASE + 1, 6);
        set_in(4'b0000);
        load_cfg();
        set_in(4'b0010);
        chk("R6 async preset", mc_dout[0], 1'b1);
        set_in(4'b0110);
        chk("R6 clear beats preset", mc_dout[0], 1'b0);
        set_in(4'b0000);
        set_in(4'b0010);
        chk("R6 preset again", mc_dout[0], 1'b1);
        set_in(4'b1010);
        chk("R6 shared clear enabled", mc_dout[0], 1'b0);
        set_in(4'b0000);

        // R6: shared clear disabled has no effect
        c.srst_en = 1'b0;
        put_mc(0, c);
        load_cfg();
        set_in(4'b0010);
        chk("R6 preset with shared clear off", mc_dout[0], 1'b1);
        set_in(4'b1010);
        chk("R6 shared clear ignored when off", mc_dout[0], 1'b1);
        set_in(4'b0000);

        // R1 R4 R7: random combinational configurations
        for (int t = 0; t < 30; t++) begin
            cfg = '0;
            for (int b = MC_TOTAL; b < W; b++)
                cfg[b] = ($urandom_range(3) == 0);
            for (int m = 0; m < N_MC; m++) begin
                c = '0;
                c.ctl     = 5'($urandom);
                c.clk_sel = clk_sel_e'($urandom_range(3));
                c.oe_sel  = oe_sel_e'($urandom_range(3));
                c.srst_en = 1'($urandom);
                put_mc(m, c);
            end
            load_cfg();
            sweep_comb("R4/R7 random combinational");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule